// File: doc/BRIEF.md
# Instruction Skip Annul Controller

This block turns a taken conditional skip into an in-place annulment of the instruction that follows, instead of moving the program counter forward by two. When the instruction that is finishing reports a true skip condition, the block raises a skip flag. That flag tells the execute stage to treat the next instruction as a no-op: it performs no register, flag, stack or memory write. The program counter still steps through the annulled instruction as usual. The same input serves conditional skips and runs of consecutive same-type instructions that skip their successors.

The block also sets the length of each instruction. An annulled instruction normally keeps the cycle count it would have had when executed, so skipping changes no timing. The exception is a table-reference or return-type instruction: when one of these is annulled, it finishes in a single cycle. The skip flag drops again once the annulled instruction completes.

Top module: `skip_annul_ctrl`

## Requirements
- R1: After a synchronous reset, `annul` is 0, whatever value it had before the reset.
- R2: When `instr_done` and `skip_cond` are both 1 in a cycle where `annul` is 0, `annul` is 1 from the next cycle on, for the whole of the following instruction.
- R3: While `annul` is 1, it stays 1 in every cycle in which `instr_done` is 0, so a multi-cycle annulled instruction is annulled in all of its cycles.
- R4: When `instr_done` is 1 in a cycle where `annul` is 1, `annul` is 0 in the next cycle.
- R5: The `skip_cond` value of an annulled instruction is ignored: it does not make the instruction after it annulled.
- R6: `skip_cond` has no effect in a cycle where `instr_done` is 0.
- R7: When an instruction is annulled and neither `dec_table` nor `dec_return` is 1, `cyc_len` equals `dec_cycles`.
- R8: When an instruction is annulled and `dec_table` or `dec_return` is 1, `cyc_len` is 1.
- R9: When `annul` is 0, `cyc_len` equals `dec_cycles`. This holds for table-reference and return instructions too.
- R10: The first instruction after an annulled one can itself skip, which annuls the instruction that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | High in the last cycle of the current instruction |
| skip_cond | input | 1 | Skip condition result of the current instruction, sampled with `instr_done` |
| dec_table | input | 1 | Current instruction is a table reference |
| dec_return | input | 1 | Current instruction is a return or return-and-skip |
| dec_cycles | input | CYC_W | Normal cycle count of the current instruction |
| annul | output | 1 | Current instruction is annulled; the execute stage suppresses all writes |
| cyc_len | output | CYC_W | Cycle count the current instruction takes |

## Verification
The main function is driven with several instruction patterns:
- A single skip followed by a one-cycle instruction. This separates a flag that is set and then cleared from one that is never set or never clears.
- A skip followed by a two-cycle ordinary instruction. This shows whether the annulment lasts the full instruction and keeps its length.
- Skips followed by table-reference and return instructions, compared with the same instructions when not annulled. These show that only annulled instructions of those types shrink to one cycle.
- An annulled instruction that reports a skip, and `skip_cond` pulses without a done strobe. These separate the skip conditions that count from those that must be ignored.
- A chain of skip, annulled instruction, skip. This shows the flag re-arming right after it clears.
- A reset applied while the flag is set. This shows that reset clears the flag.

// File: rtl/skip_annul_pkg.sv
package skip_annul_pkg;

    // Skip flag state: running normally or annulling the current instruction
    typedef enum logic {
        SK_RUN   = 1'b0,
        SK_ANNUL = 1'b1
    } skip_state_e;

    // Decode flags that affect length when annulled
    typedef struct packed {
        logic table_ref;
        logic ret;
    } dec_flags_t;

    // True when an annulled instruction of this kind collapses to one cycle
    function automatic logic collapses_when_annulled(input dec_flags_t f);
        return f.table_ref | f.ret;
    endfunction

endpackage

// File: rtl/skip_flag_reg.sv
module skip_flag_reg
    import skip_annul_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic done_i,
    input  logic cond_i,
    output logic annul_o
);

    skip_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            SK_RUN:   if (done_i && cond_i) state_d = SK_ANNUL;
            SK_ANNUL: if (done_i)           state_d = SK_RUN;   // own skip is dropped
            default:                        state_d = SK_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SK_RUN;
        else     state_q <= state_d;
    end

    assign annul_o = (state_q == SK_ANNUL);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !annul_o);

    assert_skip_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (done_i && cond_i && !annul_o) |=> annul_o);

    assert_hold_until_done_R3: assert property (@(posedge clk) disable iff (rst)
        (annul_o && !done_i) |=> annul_o);

    assert_clear_after_done_R4: assert property (@(posedge clk) disable iff (rst)
        (annul_o && done_i) |=> !annul_o);

    assert_no_reskip_R5: assert property (@(posedge clk) disable iff (rst)
        (annul_o && done_i && cond_i) |=> !annul_o);

    assert_idle_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (!annul_o && !done_i) |=> !annul_o);

endmodule

// File: rtl/cycle_len_sel.sv
module cycle_len_sel
    import skip_annul_pkg::*;
#(
    parameter int CYC_W = 2
) (
    input  logic             annul_i,
    input  dec_flags_t       flags_i,
    input  logic [CYC_W-1:0] normal_i,
    output logic [CYC_W-1:0] len_o
);

    localparam logic [CYC_W-1:0] SHORT_LEN = CYC_W'(1);

    always_comb begin
        if (annul_i && collapses_when_annulled(flags_i))
            len_o = SHORT_LEN;
        else
            len_o = normal_i;
    end

endmodule

// File: rtl/skip_annul_ctrl.sv
module skip_annul_ctrl
    import skip_annul_pkg::*;
#(
    parameter int CYC_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_done,
    input  logic             skip_cond,
    input  logic             dec_table,
    input  logic             dec_return,
    input  logic [CYC_W-1:0] dec_cycles,
    output logic             annul,
    output logic [CYC_W-1:0] cyc_len
);

    logic       annul_w;
    dec_flags_t flags_w;

    assign flags_w = '{table_ref: dec_table, ret: dec_return};

    skip_flag_reg u_flag (
        .clk     (clk),
        .rst     (rst),
        .done_i  (instr_done),
        .cond_i  (skip_cond),
        .annul_o (annul_w)
    );

    cycle_len_sel #(.CYC_W(CYC_W)) u_len (
        .annul_i  (annul_w),
        .flags_i  (flags_w),
        .normal_i (dec_cycles),
        .len_o    (cyc_len)
    );

    assign annul = annul_w;

    // Relate the length selector output to the separately driven flag
    assert_keep_len_R7: assert property (@(posedge clk) disable iff (rst)
        (annul_w && !dec_table && !dec_return) |-> (cyc_len == dec_cycles));

    assert_short_len_R8: assert property (@(posedge clk) disable iff (rst)
        (annul_w && (dec_table || dec_return)) |-> (cyc_len == CYC_W'(1)));

    assert_pass_len_R9: assert property (@(posedge clk) disable iff (rst)
        !annul_w |-> (cyc_len == dec_cycles));

    assert_rearm_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(annul_w) && !annul_w && instr_done && skip_cond) |=> annul_w);

endmodule

// File: tb/sim_skip_annul_ctrl.sv
`timescale 1ns/1ps
module sim_skip_annul_ctrl;

    localparam int CYC_W = 2;

    logic             clk = 1'b0;
    logic             rst;
    logic             instr_done;
    logic             skip_cond;
    logic             dec_table;
    logic             dec_return;
    logic [CYC_W-1:0] dec_cycles;
    logic             annul;
    logic [CYC_W-1:0] cyc_len;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    skip_annul_ctrl #(.CYC_W(CYC_W)) u0 (
        .clk(clk), .rst(rst), .instr_done(instr_done), .skip_cond(skip_cond),
        .dec_table(dec_table), .dec_return(dec_return), .dec_cycles(dec_cycles),
        .annul(annul), .cyc_len(cyc_len)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        instr_done = 0; skip_cond = 0; dec_table = 0; dec_return = 0; dec_cycles = 1;
    endtask

    // Runs one instruction. Its length follows the expected cycle count;
    // annul and cyc_len are checked in every cycle of it.
    task automatic run_instr(input string req, input bit skip, input bit tbl,
                             input bit ret, input int normal, input bit exp_annul);
        int exp_len;
        exp_len = (exp_annul && (tbl || ret)) ? 1 : normal;
        for (int c = 0; c < exp_len; c++) begin
            @(posedge clk); #1;
            dec_table  = tbl;
            dec_return = ret;
            dec_cycles = CYC_W'(normal);
            instr_done = (c == exp_len - 1);
            skip_cond  = (c == exp_len - 1) ? skip : 1'b0;
            #1;
            check(req, int'(annul), int'(exp_annul));
            check(req, int'(cyc_len), exp_len);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1; idle_inputs();
        @(posedge clk); #1;
        rst = 0;
    endtask

    task automatic t_reset();
        do_reset();
        #1 check("R1", int'(annul), 0);
    endtask

    task automatic t_basic();
        run_instr("R2", 1, 0, 0, 1, 0);
        run_instr("R2/R7", 0, 0, 0, 1, 1);
        run_instr("R4", 0, 0, 0, 1, 0);
    endtask

    task automatic t_multi_cycle();
        run_instr("R2", 1, 0, 0, 1, 0);
        run_instr("R3/R7", 0, 0, 0, 2, 1);
        run_instr("R4", 0, 0, 0, 2, 0);
    endtask

    task automatic t_collapse();
        run_instr("R9 table", 1, 1, 0, 2, 0);
        run_instr("R8 table", 0, 1, 0, 2, 1);
        run_instr("R9 ret", 1, 0, 1, 2, 0);
        run_instr("R8 ret", 0, 0, 1, 2, 1);
        run_instr("R4", 0, 0, 0, 1, 0);
    endtask

    task automatic t_no_reskip();
        run_instr("R2", 1, 0, 0, 1, 0);
        run_instr("R5", 1, 0, 0, 1, 1);
        run_instr("R5", 0, 0, 0, 1, 0);
    endtask

    task automatic t_strobe_needed();
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #1;
            instr_done = 0; skip_cond = 1; dec_cycles = 3;
            #1 check("R6", int'(annul), 0);
        end
        @(posedge clk); #1;
        instr_done = 1; skip_cond = 0;
        #1 check("R6", int'(annul), 0);
        run_instr("R6", 0, 0, 0, 1, 0);
    endtask

    task automatic t_chain();
        run_instr("R2", 1, 0, 0, 1, 0);
        run_instr("R10", 0, 0, 0, 1, 1);
        run_instr("R10", 1, 0, 0, 1, 0);
        run_instr("R10", 0, 0, 0, 2, 1);
        run_instr("R10", 0, 0, 0, 1, 0);
    endtask

    task automatic t_reset_while_set();
        run_instr("R2", 1, 0, 0, 1, 0);
        do_reset();
        #1 check("R1 mid", int'(annul), 0);
    endtask

    initial begin
        rst = 1; idle_inputs();
        repeat (2) @(posedge clk);
        t_reset();
        t_basic();
        t_multi_cycle();
        t_collapse();
        t_no_reskip();
        t_strobe_needed();
        t_chain();
        t_reset_while_set();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule